// File: doc/BRIEF.md
# Multi-Channel External Interrupt Sense Controller

This block watches up to 32 external interrupt pins and folds them into one interrupt line towards a processor. Each pin is brought into the clock domain through a two-stage synchroniser. A per-channel sense mode then turns the pin into detection events: active-low level, active-high level, falling edge, rising edge or either edge. Events are latched into a sticky detect status word. Software clears a status bit by writing a 1 to it. A per-channel enable mask, changed through separate set and clear addresses, gates the latched status into a request word. The OR of the request word drives the single interrupt output.

Software reaches the block over a plain 32-bit register bus that is byte-addressed on word boundaries. A write takes effect on the clock edge at which `busSel` and `busWrite` are both high. Read data is combinational from the current address. Each channel has its own 32-bit configuration word. The low six bits of that word select the sense mode, and the upper bits are stored and read back unchanged.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset the enable mask, detect status, synchroniser stages and every configuration word are zero, and `cpuIrq` is low.
- R2: Each pin passes through two flops. Offset 0x104 reads the synchronised pin levels. A pin change made before clock edge k first appears at that offset after edge k+1.
- R3: Sense code 0x02 (active-high level) and code 0x01 (active-low level) set the channel's status bit on every clock while the synchronised level is active. A clear written while the level is still active therefore leaves the bit set.
- R4: Sense code 0x08 (rising), code 0x04 (falling) and code 0x0C (either edge) compare the synchronised level with its previous sample. The status bit is set on the clock edge after the synchronised level changes in the selected direction.
- R5: Any value of the low six configuration bits other than 0x01, 0x02, 0x04, 0x08 or 0x0C disables detection for that channel.
- R6: The configuration word for channel n is at offset 0x180 + 4*n. All 32 written bits are stored and read back. Bits [5:0] are the sense code.
- R7: The detect status word at offset 0x100 is sticky. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged. A detection in the same cycle as the clear wins.
- R8: Writing to offset 0x08 ORs the written ones into the enable mask, and zeros have no effect. Offset 0x08 reads as zero.
- R9: Writing to offset 0x04 clears the enable bits at the written ones. Reading offset 0x04 returns the enable mask.
- R10: Offset 0x00 reads as the detect status ANDed with the enable mask. Writes to this offset change nothing.
- R11: `cpuIrq` is high exactly when the request word of R10 is non-zero.
- R12: Unmapped, misaligned or out-of-range offsets read as zero and ignore writes. When `busSel` is low, `busRdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_CH | Raw external interrupt pins |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe (with busSel) |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| cpuIrq | output | 1 | Combined interrupt request |

## Verification
The in-RTL properties check these rules on every clock: enable bits change only as the set and clear writes dictate, status bits never drop without a clear, every detection lands in the status word, a configuration write is stored whole, and the interrupt stays low when nothing is enabled. What only the bench scenarios can show is the end-to-end timing. That covers the two-flop latency seen at the monitor offset, level re-assertion defeating a clear, the direction selectivity of each edge mode, and the silence of an invalid sense code. These are compared every clock against a behavioural model and through targeted reads.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int DATA_W  = 32;
  localparam int SENSE_W = 6;
  localparam int IDX_W   = 5;

  localparam int OFS_REQ   = 'h000;
  localparam int OFS_ENCLR = 'h004;
  localparam int OFS_ENSET = 'h008;
  localparam int OFS_STAT  = 'h100;
  localparam int OFS_MON   = 'h104;
  localparam int OFS_CFG   = 'h180;

  localparam logic [SENSE_W-1:0] SENSE_LOW  = 6'h01;
  localparam logic [SENSE_W-1:0] SENSE_HIGH = 6'h02;
  localparam logic [SENSE_W-1:0] SENSE_FALL = 6'h04;
  localparam logic [SENSE_W-1:0] SENSE_RISE = 6'h08;
  localparam logic [SENSE_W-1:0] SENSE_BOTH = 6'h0C;

  typedef enum logic [2:0] {
    RD_NONE, RD_REQ, RD_EN, RD_STAT, RD_MON, RD_CFG
  } rdSel_e;

  typedef struct packed {
    logic             enSet;
    logic             enClr;
    logic             statClr;
    logic             cfgWr;
    logic [IDX_W-1:0] cfgIdx;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/extint_chan_detect.sv
module extint_chan_detect
  import extint_pkg::*;
(
  input  logic               curLvl,
  input  logic               prevLvl,
  input  logic [SENSE_W-1:0] senseMode,
  output logic               hit
);
  always_comb begin
    unique case (senseMode)
      SENSE_LOW:  hit = !curLvl;
      SENSE_HIGH: hit = curLvl;
      SENSE_FALL: hit = prevLvl && !curLvl;
      SENSE_RISE: hit = !prevLvl && curLvl;
      SENSE_BOTH: hit = prevLvl ^ curLvl;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] CFG_BASE = ADDR_W'(OFS_CFG);

  logic cfgHit;

  always_comb begin
    cfgHit = (busAddr[ADDR_W-1:7] == CFG_BASE[ADDR_W-1:7])
          && (busAddr[1:0] == 2'b00)
          && (int'(busAddr[6:2]) < NUM_CH);
  end

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (busSel) begin
      if (busAddr == ADDR_W'(OFS_REQ)) begin
        stb.rdSel = RD_REQ;
      end else if (busAddr == ADDR_W'(OFS_ENCLR)) begin
        stb.rdSel = RD_EN;
        stb.enClr = busWrite;
      end else if (busAddr == ADDR_W'(OFS_ENSET)) begin
        stb.enSet = busWrite;
      end else if (busAddr == ADDR_W'(OFS_STAT)) begin
        stb.rdSel   = RD_STAT;
        stb.statClr = busWrite;
      end else if (busAddr == ADDR_W'(OFS_MON)) begin
        stb.rdSel = RD_MON;
      end else if (cfgHit) begin
        stb.rdSel  = RD_CFG;
        stb.cfgWr  = busWrite;
        stb.cfgIdx = busAddr[6:2];
      end
    end
  end
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cpuIrq
);
  logic [NUM_CH-1:0] syncA, syncB, prevLvl;
  logic [NUM_CH-1:0] statusQ, enableQ, hitVec, wMask, reqVec;
  logic [DATA_W-1:0] cfgQ [NUM_CH];

  assign wMask  = wdata[NUM_CH-1:0];
  assign reqVec = statusQ & enableQ;
  assign cpuIrq = |reqVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    extint_chan_detect u_det (
      .curLvl   (syncB[ch]),
      .prevLvl  (prevLvl[ch]),
      .senseMode(cfgQ[ch][SENSE_W-1:0]),
      .hit      (hitVec[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgQ[ch] <= '0;
      else if (stb.cfgWr && stb.cfgIdx == IDX_W'(ch)) cfgQ[ch] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else statusQ <= (statusQ & ~(stb.statClr ? wMask : '0)) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableQ <= '0;
    else if (stb.enSet) enableQ <= enableQ | wMask;
    else if (stb.enClr) enableQ <= enableQ & ~wMask;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_REQ:  rdata = DATA_W'(reqVec);
      RD_EN:   rdata = DATA_W'(enableQ);
      RD_STAT: rdata = DATA_W'(statusQ);
      RD_MON:  rdata = DATA_W'(syncB);
      RD_CFG:  rdata = cfgQ[stb.cfgIdx];
      default: rdata = '0;
    endcase
  end

  // R8: set write raises the written bits and keeps the others
  p_en_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enableQ & $past(wMask)) == $past(wMask))
               && ((enableQ & ~$past(wMask)) == ($past(enableQ) & ~$past(wMask))));

  // R9: clear write drops the written bits
  p_en_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enableQ & $past(wMask)) == '0));

  // R7: status bits never fall without a clear write
  p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.statClr |=> (($past(statusQ) & ~statusQ) == '0));

  // R7: cleared bits without a competing detection read back zero
  p_stat_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.statClr |=> ((statusQ & $past(wMask & ~hitVec)) == '0));

  // R4: every detection is latched on the next edge
  p_hit_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((statusQ & $past(hitVec)) == $past(hitVec)));

  // R6: a configuration write is stored in full
  p_cfg_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> (cfgQ[$past(stb.cfgIdx)] == $past(wdata)));

  // R11: no interrupt with an empty enable mask
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !cpuIrq);
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              cpuIrq
);
  strobe_t stb;

  extint_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  extint_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (pinIn),
    .stb   (stb),
    .wdata (busWdata),
    .rdata (busRdata),
    .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/extint_sense_ctrl_tb_top.sv
module extint_sense_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pins = '0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cpuIrq;

  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pins), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cpuIrq(cpuIrq)
  );

  // behavioural reference model
  logic [31:0] mS1 = '0, mS2 = '0, mPrev = '0, mStat = '0, mEn = '0;
  logic [31:0] mCfg [32];

  function automatic logic mDetect(input logic [5:0] s, input logic now, input logic was);
    if (s == 6'h01) return !now;
    if (s == 6'h02) return now;
    if (s == 6'h04) return was && !now;
    if (s == 6'h08) return !was && now;
    if (s == 6'h0C) return was != now;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expRd(input logic sel, input logic [11:0] a);
    if (!sel) return '0;
    if (a == 12'h000) return mStat & mEn;
    if (a == 12'h004) return mEn;
    if (a == 12'h100) return mStat;
    if (a == 12'h104) return mS2;
    if (a >= 12'h180 && a <= 12'h1FC && a[1:0] == 2'b00) return mCfg[a[6:2]];
    return '0;
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    if (a == 12'h000) return "R10";
    if (a == 12'h004) return "R9";
    if (a == 12'h008) return "R8";
    if (a == 12'h100) return "R7";
    if (a == 12'h104) return "R2";
    if (a >= 12'h180 && a <= 12'h1FC && a[1:0] == 2'b00) return "R6";
    return "R12";
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mStat = '0; mEn = '0;
      for (int i = 0; i < 32; i++) mCfg[i] = '0;
    end else begin
      logic [31:0] det, clr;
      for (int i = 0; i < 32; i++) det[i] = mDetect(mCfg[i][5:0], mS2[i], mPrev[i]);
      clr = '0;
      if (busSel && busWrite) begin
        if (busAddr == 12'h008) mEn = mEn | busWdata;
        else if (busAddr == 12'h004) mEn = mEn & ~busWdata;
        else if (busAddr == 12'h100) clr = busWdata;
        else if (busAddr >= 12'h180 && busAddr <= 12'h1FC && busAddr[1:0] == 2'b00)
          mCfg[busAddr[6:2]] = busWdata;
      end
      mStat = (mStat & ~clr) | det;
      mPrev = mS2; mS2 = mS1; mS1 = pins;
    end
    #(CLK_PERIOD/4);
    if (rstN) begin
      cmp(tagFor(busAddr), busRdata, expRd(busSel, busAddr));
      cmp("R11", {31'b0, cpuIrq}, {31'b0, ((mStat & mEn) != 0)});
    end
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busSel = 1'b0; busWdata = '0;
  endtask

  task automatic checkRd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    #(CLK_PERIOD/4);
    cmp(tag, busRdata, exp);
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    cmp(tag, {31'b0, cpuIrq}, {31'b0, exp});
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkRd(12'h000, 32'h0, "R1");
    checkRd(12'h004, 32'h0, "R1");
    checkRd(12'h100, 32'h0, "R1");
    checkRd(12'h104, 32'h0, "R1");
    checkRd(12'h180, 32'h0, "R1");
    checkIrq(1'b0, "R1");
    // R6 full word stored, sense rising on ch0
    busWr(12'h180, 32'hABCD_EF08);
    checkRd(12'h180, 32'hABCD_EF08, "R6");
    checkRd(12'h184, 32'h0, "R6");
    // R4 rising edge on ch0
    setPins(32'h1); idle(4);
    checkRd(12'h100, 32'h1, "R4");
    checkRd(12'h000, 32'h0, "R10");
    checkIrq(1'b0, "R11");
    // R8 enable set
    busWr(12'h008, 32'h1);
    checkRd(12'h004, 32'h1, "R8");
    checkRd(12'h008, 32'h0, "R8");
    checkRd(12'h000, 32'h1, "R10");
    checkIrq(1'b1, "R11");
    busWr(12'h008, 32'h0);
    checkRd(12'h004, 32'h1, "R8");
    // R7 write-one-to-clear
    busWr(12'h100, 32'h0);
    checkRd(12'h100, 32'h1, "R7");
    busWr(12'h100, 32'h1);
    checkRd(12'h100, 32'h0, "R7");
    checkIrq(1'b0, "R11");
    // R3 high level on ch1
    busWr(12'h184, 32'h02);
    setPins(32'h3); idle(4);
    checkRd(12'h100, 32'h2, "R3");
    busWr(12'h100, 32'h2);
    checkRd(12'h100, 32'h2, "R3");
    setPins(32'h1); idle(4);
    busWr(12'h100, 32'h2);
    checkRd(12'h100, 32'h0, "R3");
    // R3 low level on ch2
    busWr(12'h188, 32'h01); idle(3);
    checkRd(12'h100, 32'h4, "R3");
    setPins(32'h5); idle(4);
    busWr(12'h100, 32'h4);
    checkRd(12'h100, 32'h0, "R3");
    // R4 falling on ch3
    busWr(12'h18C, 32'h04);
    setPins(32'hD); idle(4);
    checkRd(12'h100, 32'h0, "R4");
    setPins(32'h5); idle(4);
    checkRd(12'h100, 32'h8, "R4");
    busWr(12'h100, 32'h8);
    // R4 both edges on ch4
    busWr(12'h190, 32'h0C);
    setPins(32'h15); idle(4);
    checkRd(12'h100, 32'h10, "R4");
    busWr(12'h100, 32'h10);
    checkRd(12'h100, 32'h0, "R4");
    setPins(32'h5); idle(4);
    checkRd(12'h100, 32'h10, "R4");
    busWr(12'h100, 32'h10);
    // R5 invalid sense code on ch5
    busWr(12'h194, 32'h03);
    setPins(32'h25); idle(4);
    setPins(32'h5); idle(4);
    checkRd(12'h100, 32'h0, "R5");
    // R2 monitor latency
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 12'h104;
    pins = 32'hF0F0_0005;
    @(posedge clk); #(CLK_PERIOD/4);
    cmp("R2", busRdata, 32'h0000_0005);
    @(posedge clk); #(CLK_PERIOD/4);
    cmp("R2", busRdata, 32'hF0F0_0005);
    // R9 enable clear
    busWr(12'h008, 32'hFFFF_FFFF);
    checkRd(12'h004, 32'hFFFF_FFFF, "R9");
    busWr(12'h004, 32'h0000_FFFF);
    checkRd(12'h004, 32'hFFFF_0000, "R9");
    // R10 / R12 ignored writes
    busWr(12'h000, 32'hFFFF_FFFF);
    checkRd(12'h004, 32'hFFFF_0000, "R10");
    checkRd(12'h100, 32'h0, "R10");
    busWr(12'h040, 32'hFFFF_FFFF);
    checkRd(12'h040, 32'h0, "R12");
    busWr(12'h186, 32'h0000_0008);
    checkRd(12'h184, 32'h02, "R12");
    checkRd(12'h186, 32'h0, "R12");
    // R11 interrupt follows request word
    busWr(12'h008, 32'h8);
    setPins(32'hF0F0_000D); idle(4);
    setPins(32'hF0F0_0005); idle(4);
    checkRd(12'h000, 32'h8, "R10");
    checkIrq(1'b1, "R11");
    busWr(12'h004, 32'h8);
    checkRd(12'h100, 32'h8, "R11");
    checkRd(12'h000, 32'h0, "R11");
    checkIrq(1'b0, "R11");
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule